// File: doc/BRIEF.md
# Event Status Latch and Interrupt Request

This block collects event indications for a position-counter subsystem and turns them into sticky status flags plus a single interrupt request line. Three inputs arrive asynchronously from field wiring: a capture line, a halt line and a home line. Each passes through a synchroniser and then through a per-line polarity selection. Four more events arrive as single-cycle pulses from the neighbouring counter logic: counter overflow, counter underflow, compare match and period-timer expiry.

Every event sets its own status flag. The flag stays set until software clears it, and while it is set, further events of that kind are ignored. Software clears flags through a write port. The port carries one acknowledge bit per flag, and writing 0 to a bit clears the matching flag. The acknowledge field always reads back as all ones, so a read-modify-write cannot clear a flag by accident.

The interrupt request is a registered OR of the enabled flags. When the period-timer source is enabled, it masks every other source. When a halt flag raises an enabled interrupt, a one-cycle pulse tells the counter to set its inhibit control.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Each asynchronous line is sampled by two flops in series, so a level change set up before clock edge N shows in `status` after edge N+2 and not after edge N+1.
- R2: Each asynchronous line has a polarity select. With the select at 0, a high level is the true condition. With the select at 1, a low level is the true condition. A change of the select takes effect on the already synchronised level.
- R3: The capture flag (`status[3]`) is set only by a change of the capture line from not-true to true, and only while `latch_en` is 1. A true level that is held does not set it again after it is cleared.
- R4: The halt flag (`status[4]`) is set whenever the halt line is true while `stop_en` is 1, and it sets again on the next edge after a clear if the condition still holds. The home flag (`status[5]`) is set whenever the home line is true, with no enable.
- R5: A set status flag stays set until it is acknowledged, and events of its kind that arrive while it is set are discarded.
- R6: On an edge with `wr_en` at 1, each bit of `wr_ack` that is 0 clears the status flag at the same index, and each bit at 1 leaves its flag unchanged. An event that arrives in the same cycle as the clear of its set flag is discarded. The index order is: 0 overflow, 1 underflow, 2 compare, 3 capture, 4 halt, 5 home, 6 timer.
- R7: `ack_rb` reads as all ones (7'h7F) at all times, including during and after reset.
- R8: After reset, `status`, `irq` and `inhibit_set` are 0.
- R9: `irq` is a register. After edge N it is 1 exactly when, before edge N, some flag among `status[6:2]` was set with its enable in `irq_en` at 1. The enable order is: bit 0 compare, 1 capture, 2 halt, 3 home, 4 timer. The overflow and underflow flags never raise `irq`.
- R10: While `irq_en[4]` is 1, only the timer flag can raise `irq`. All other enables are masked.
- R11: `inhibit_set` is 1 for exactly the cycle after the edge on which the halt flag goes from 0 to 1 while the halt interrupt is enabled and not masked.
- R12: A pulse on `carry_evt`, `borrow_evt`, `cmp_eq_evt` or `timer_evt` that is high before edge N sets its flag after edge N, provided the flag was clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_pin | input | 1 | Asynchronous capture line |
| stop_pin | input | 1 | Asynchronous halt line |
| origin_pin | input | 1 | Asynchronous home line |
| latch_sel_low | input | 1 | Capture line polarity: 1 means low is true |
| stop_sel_low | input | 1 | Halt line polarity: 1 means low is true |
| origin_sel_low | input | 1 | Home line polarity: 1 means low is true |
| latch_en | input | 1 | Enables recording of capture events |
| stop_en | input | 1 | Enables recording of halt events |
| carry_evt | input | 1 | Counter overflow pulse |
| borrow_evt | input | 1 | Counter underflow pulse |
| cmp_eq_evt | input | 1 | Compare-match pulse |
| timer_evt | input | 1 | Period-timer expiry pulse |
| irq_en | input | 5 | Interrupt enables: 0 compare, 1 capture, 2 halt, 3 home, 4 timer |
| wr_en | input | 1 | Acknowledge write strobe |
| wr_ack | input | 7 | Acknowledge bits; 0 clears the matching flag |
| status | output | 7 | Sticky flags: 0 overflow, 1 underflow, 2 compare, 3 capture, 4 halt, 5 home, 6 timer |
| irq | output | 1 | Registered interrupt request |
| inhibit_set | output | 1 | One-cycle request to set the counter inhibit |
| ack_rb | output | 7 | Readback of the acknowledge field, always ones |

## Verification
Directed sequences come first. The capture line is stepped and then held, which shows whether the block reacts to the change or to the level. The halt line is held true across an acknowledge, which separates level recording from edge recording and exposes the re-set on the next cycle. Each polarity select is flipped while its line is quiet, so an inverted select shows up as a spurious or missing flag. The interrupt enables are tried with the timer enable both set and clear, which shows whether the mask is applied. A long random phase then drives lines, polarities, enables, pulses and acknowledge writes together, so that event-during-clear and masked-enable corner cases occur often. A behavioural model is compared with the outputs on every cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int NUM_PINS   = 3;
    localparam int PIN_LATCH  = 0;
    localparam int PIN_STOP   = 1;
    localparam int PIN_ORIGIN = 2;

    localparam int NUM_STAT  = 7;
    localparam int ST_CARRY  = 0;
    localparam int ST_BORROW = 1;
    localparam int ST_CMP    = 2;
    localparam int ST_LATCH  = 3;
    localparam int ST_STOP   = 4;
    localparam int ST_ORIGIN = 5;
    localparam int ST_TIMER  = 6;

    localparam int NUM_IRQ   = 5;
    localparam int IE_CMP    = 0;
    localparam int IE_LATCH  = 1;
    localparam int IE_STOP   = 2;
    localparam int IE_ORIGIN = 3;
    localparam int IE_TIMER  = 4;
    // interrupt source k maps to status bit IRQ_BASE + k
    localparam int IRQ_BASE  = ST_CMP;

    typedef logic [NUM_STAT-1:0] stat_vec_t;
    typedef logic [NUM_IRQ-1:0]  ie_vec_t;

    typedef struct packed {
        logic origin_lvl;
        logic stop_lvl;
        logic latch_edge;
    } pin_evt_t;

    function automatic stat_vec_t ack_to_clear(input logic wr, input stat_vec_t ack);
        return wr ? ~ack : '0;
    endfunction

    function automatic ie_vec_t mask_enables(input ie_vec_t ie);
        ie_vec_t only_timer;
        only_timer = '0;
        only_timer[IE_TIMER] = 1'b1;
        return ie[IE_TIMER] ? (ie & only_timer) : ie;
    endfunction

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic sel_low_i,
    output logic true_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign true_o = chain_q[STAGES-1] ^ sel_low_i;
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_vec_t evt_i,
    input  stat_vec_t clr_i,
    output stat_vec_t status_o,
    output stat_vec_t rise_o
);
    stat_vec_t st_q;
    stat_vec_t st_d;

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_bit
        // a set flag only clears; a clear flag only records
        always_comb begin
            if (st_q[i]) st_d[i] = ~clr_i[i];
            else         st_d[i] = evt_i[i];
        end

        always_ff @(posedge clk) begin
            if (rst) st_q[i] <= 1'b0;
            else     st_q[i] <= st_d[i];
        end

        assign rise_o[i] = st_d[i] & ~st_q[i];
    end

    assign status_o = st_q;
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen
    import evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_vec_t status_i,
    input  stat_vec_t rise_i,
    input  ie_vec_t   ie_i,
    output logic      irq_o,
    output logic      inhibit_o
);
    ie_vec_t eff_ie;
    ie_vec_t src_hit;

    assign eff_ie = mask_enables(ie_i);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
        assign src_hit[k] = status_i[IRQ_BASE + k] & eff_ie[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o     <= 1'b0;
            inhibit_o <= 1'b0;
        end else begin
            irq_o     <= |src_hit;
            inhibit_o <= rise_i[ST_STOP] & eff_ie[IE_STOP];
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       latch_pin,
    input  logic       stop_pin,
    input  logic       origin_pin,
    input  logic       latch_sel_low,
    input  logic       stop_sel_low,
    input  logic       origin_sel_low,
    input  logic       latch_en,
    input  logic       stop_en,
    input  logic       carry_evt,
    input  logic       borrow_evt,
    input  logic       cmp_eq_evt,
    input  logic       timer_evt,
    input  logic [4:0] irq_en,
    input  logic       wr_en,
    input  logic [6:0] wr_ack,
    output logic [6:0] status,
    output logic       irq,
    output logic       inhibit_set,
    output logic [6:0] ack_rb
);
    logic [NUM_PINS-1:0] pin_raw;
    logic [NUM_PINS-1:0] pin_sel;
    logic [NUM_PINS-1:0] pin_true;
    logic                latch_prev_q;
    pin_evt_t            pev;
    stat_vec_t           evt_vec;
    stat_vec_t           clr_vec;
    stat_vec_t           st_vec;
    stat_vec_t           rise_vec;

    assign pin_raw[PIN_LATCH]  = latch_pin;
    assign pin_raw[PIN_STOP]   = stop_pin;
    assign pin_raw[PIN_ORIGIN] = origin_pin;
    assign pin_sel[PIN_LATCH]  = latch_sel_low;
    assign pin_sel[PIN_STOP]   = stop_sel_low;
    assign pin_sel[PIN_ORIGIN] = origin_sel_low;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (pin_raw[p]),
            .sel_low_i (pin_sel[p]),
            .true_o    (pin_true[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) latch_prev_q <= 1'b0;
        else     latch_prev_q <= pin_true[PIN_LATCH];
    end

    assign pev.latch_edge = latch_en & pin_true[PIN_LATCH] & ~latch_prev_q;
    assign pev.stop_lvl   = stop_en & pin_true[PIN_STOP];
    assign pev.origin_lvl = pin_true[PIN_ORIGIN];

    always_comb begin
        evt_vec            = '0;
        evt_vec[ST_CARRY]  = carry_evt;
        evt_vec[ST_BORROW] = borrow_evt;
        evt_vec[ST_CMP]    = cmp_eq_evt;
        evt_vec[ST_LATCH]  = pev.latch_edge;
        evt_vec[ST_STOP]   = pev.stop_lvl;
        evt_vec[ST_ORIGIN] = pev.origin_lvl;
        evt_vec[ST_TIMER]  = timer_evt;
    end

    assign clr_vec = ack_to_clear(wr_en, wr_ack);

    evt_status_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_vec),
        .clr_i    (clr_vec),
        .status_o (st_vec),
        .rise_o   (rise_vec)
    );

    evt_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .status_i  (st_vec),
        .rise_i    (rise_vec),
        .ie_i      (irq_en),
        .irq_o     (irq),
        .inhibit_o (inhibit_set)
    );

    assign status = st_vec;
    assign ack_rb = '1;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       latch_en,
    input logic       stop_en,
    input logic [4:0] irq_en,
    input logic       wr_en,
    input logic [6:0] wr_ack,
    input logic [6:0] status,
    input logic       irq,
    input logic       inhibit_set
);
    logic [6:0] clr_req;
    assign clr_req = wr_en ? ~wr_ack : 7'h00;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status) & ~$past(clr_req)) & ~status) == 7'h00)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status) & $past(clr_req)) & status) == 7'h00)); // R6

    AST_LATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> $past(latch_en)); // R3

    AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> $past(stop_en)); // R4

    AST_TIMER_MASK: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_en[4]) && !$past(status[6])) |-> !irq); // R10

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(status[6:2]) != 5'b00000)); // R9

    AST_INHIBIT_ON_STOP_RISE: assert property (@(posedge clk) disable iff (rst)
        inhibit_set |-> $rose(status[4])); // R11
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .latch_en    (latch_en),
    .stop_en     (stop_en),
    .irq_en      (irq_en),
    .wr_en       (wr_en),
    .wr_ack      (wr_ack),
    .status      (status),
    .irq         (irq),
    .inhibit_set (inhibit_set)
);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       latch_pin = 0, stop_pin = 0, origin_pin = 0;
    logic       latch_sel_low = 0, stop_sel_low = 0, origin_sel_low = 0;
    logic       latch_en = 0, stop_en = 0;
    logic       carry_evt = 0, borrow_evt = 0, cmp_eq_evt = 0, timer_evt = 0;
    logic [4:0] irq_en = 5'h00;
    logic       wr_en = 0;
    logic [6:0] wr_ack = 7'h7F;
    logic [6:0] status;
    logic       irq;
    logic       inhibit_set;
    logic [6:0] ack_rb;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u0 (
        .clk(clk), .rst(rst),
        .latch_pin(latch_pin), .stop_pin(stop_pin), .origin_pin(origin_pin),
        .latch_sel_low(latch_sel_low), .stop_sel_low(stop_sel_low),
        .origin_sel_low(origin_sel_low),
        .latch_en(latch_en), .stop_en(stop_en),
        .carry_evt(carry_evt), .borrow_evt(borrow_evt),
        .cmp_eq_evt(cmp_eq_evt), .timer_evt(timer_evt),
        .irq_en(irq_en), .wr_en(wr_en), .wr_ack(wr_ack),
        .status(status), .irq(irq), .inhibit_set(inhibit_set), .ack_rb(ack_rb)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- behavioural reference ----------------
    bit [2:0] hist1, hist2;      // pin samples one and two edges old
    bit       cap_was_true;
    bit [6:0] m_status;
    bit       m_irq, m_inh;
    bit [6:0] ev;
    bit [4:0] usable;
    bit       t_cap, t_halt, t_home, halt_before;

    always @(posedge clk) begin
        if (rst) begin
            m_status = 0; m_irq = 0; m_inh = 0; cap_was_true = 0;
            hist1 = 0; hist2 = 0;
        end else begin
            t_cap  = hist2[0] ^ latch_sel_low;
            t_halt = hist2[1] ^ stop_sel_low;
            t_home = hist2[2] ^ origin_sel_low;
            ev = {timer_evt, t_home, stop_en & t_halt,
                  latch_en & t_cap & ~cap_was_true, cmp_eq_evt, borrow_evt, carry_evt};
            usable = irq_en[4] ? 5'b10000 : irq_en;
            m_irq = 0;
            for (int k = 0; k < 5; k++)
                if (m_status[k+2] && usable[k]) m_irq = 1;
            halt_before = m_status[4];
            for (int i = 0; i < 7; i++) begin
                if (m_status[i]) begin
                    if (wr_en && !wr_ack[i]) m_status[i] = 0;
                end else begin
                    m_status[i] = ev[i];
                end
            end
            m_inh = !halt_before && m_status[4] && usable[2];
            cap_was_true = t_cap;
            hist2 = hist1;
            hist1 = {origin_pin, stop_pin, latch_pin};
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R12 overflow flag", 32'(status[0]), 32'(m_status[0]));
            check("R12 underflow flag", 32'(status[1]), 32'(m_status[1]));
            check("R12 compare flag", 32'(status[2]), 32'(m_status[2]));
            check("R3 capture flag", 32'(status[3]), 32'(m_status[3]));
            check("R4 halt flag", 32'(status[4]), 32'(m_status[4]));
            check("R4 home flag", 32'(status[5]), 32'(m_status[5]));
            check("R12 timer flag", 32'(status[6]), 32'(m_status[6]));
            check("R9 irq", 32'(irq), 32'(m_irq));
            check("R11 inhibit_set", 32'(inhibit_set), 32'(m_inh));
            check("R7 ack_rb", 32'(ack_rb), 32'h7F);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic ack(input int idx);
        wr_en = 1; wr_ack = 7'h7F & ~(7'(1) << idx);
        tick(1);
        wr_en = 0; wr_ack = 7'h7F;
    endtask

    initial begin
        tick(3);
        check("R8 status reset", 32'(status), 0);
        check("R8 irq reset", 32'(irq), 0);
        check("R8 inhibit reset", 32'(inhibit_set), 0);
        check("R7 readback in reset", 32'(ack_rb), 32'h7F);
        rst = 0;
        tick(2);

        // R1 / R3: capture edge with two-flop delay
        latch_en = 1; latch_pin = 1;
        tick(2); check("R1 not yet after two edges", 32'(status[3]), 0);
        tick(1); check("R1 set after three edges", 32'(status[3]), 1);
        // R5: further edges ignored while set
        latch_pin = 0; tick(4); latch_pin = 1; tick(4);
        check("R5 flag stays set", 32'(status[3]), 1);
        ack(3);
        check("R6 ack clears capture", 32'(status[3]), 0);
        tick(5);
        check("R3 held level does not re-set", 32'(status[3]), 0);

        // R2: inverted polarity
        latch_sel_low = 1; tick(4);
        check("R2 high is false when select is 1", 32'(status[3]), 0);
        latch_pin = 0;
        tick(2); check("R2 low-true not yet", 32'(status[3]), 0);
        tick(1); check("R2 low-true edge recorded", 32'(status[3]), 1);
        ack(3);
        latch_en = 0;
        latch_pin = 1; tick(4); latch_pin = 0; tick(5);
        check("R3 disabled capture ignored", 32'(status[3]), 0);
        latch_sel_low = 0; tick(4);

        // R4 / R11: halt level and inhibit pulse
        irq_en = 5'b00100; stop_pin = 1; stop_en = 0;
        tick(5); check("R4 halt ignored while disabled", 32'(status[4]), 0);
        stop_en = 1;
        tick(1);
        check("R4 halt recorded", 32'(status[4]), 1);
        check("R11 inhibit pulse", 32'(inhibit_set), 1);
        check("R9 irq lags flag", 32'(irq), 0);
        tick(1);
        check("R9 irq raised", 32'(irq), 1);
        check("R11 pulse one cycle", 32'(inhibit_set), 0);
        ack(4);
        check("R6 ack clears halt", 32'(status[4]), 0);
        tick(1);
        check("R4 level sets again", 32'(status[4]), 1);
        check("R11 pulse on re-set", 32'(inhibit_set), 1);
        stop_en = 0; stop_pin = 0; tick(1);
        ack(4); tick(3);

        // R10: timer enable masks others
        irq_en = 5'b10001; cmp_eq_evt = 1; tick(1); cmp_eq_evt = 0;
        check("R12 compare pulse", 32'(status[2]), 1);
        tick(2); check("R10 compare masked", 32'(irq), 0);
        irq_en = 5'b00001; tick(1);
        check("R9 compare irq", 32'(irq), 1);
        ack(2); tick(1);
        check("R6 irq drops after ack", 32'(irq), 0);
        irq_en = 5'b10000; timer_evt = 1; tick(1); timer_evt = 0;
        tick(1); check("R10 timer irq", 32'(irq), 1);
        ack(6); tick(2);

        // R12 / R9: overflow and underflow never interrupt
        irq_en = 5'b01111; carry_evt = 1; borrow_evt = 1; tick(1);
        carry_evt = 0; borrow_evt = 0;
        check("R12 overflow and underflow", 32'(status[1:0]), 3);
        tick(2); check("R9 no irq from overflow", 32'(irq), 0);
        wr_en = 1; wr_ack = 7'h7C; tick(1); wr_en = 0; wr_ack = 7'h7F;
        check("R6 two flags cleared", 32'(status[1:0]), 0);

        // R6: writing ones has no effect
        irq_en = 0; origin_pin = 1; tick(3);
        check("R4 home flag", 32'(status[5]), 1);
        wr_en = 1; wr_ack = 7'h7F; tick(1); wr_en = 0;
        check("R6 ones leave flag", 32'(status[5]), 1);
        check("R7 readback", 32'(ack_rb), 32'h7F);
        origin_pin = 0; ack(5); tick(2);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 8 == 0)  latch_pin  = ~latch_pin;
            if ($urandom % 8 == 0)  stop_pin   = ~stop_pin;
            if ($urandom % 8 == 0)  origin_pin = ~origin_pin;
            if ($urandom % 64 == 0) latch_sel_low  = ~latch_sel_low;
            if ($urandom % 64 == 0) stop_sel_low   = ~stop_sel_low;
            if ($urandom % 64 == 0) origin_sel_low = ~origin_sel_low;
            if ($urandom % 16 == 0) latch_en = ~latch_en;
            if ($urandom % 16 == 0) stop_en  = ~stop_en;
            carry_evt  = ($urandom % 16 == 0);
            borrow_evt = ($urandom % 16 == 0);
            cmp_eq_evt = ($urandom % 16 == 0);
            timer_evt  = ($urandom % 16 == 0);
            if ($urandom % 32 == 0) irq_en = 5'($urandom);
            wr_en = ($urandom % 6 == 0);
            wr_ack = ($urandom % 2 == 0) ? 7'($urandom) : (7'h7F & ~(7'(1) << ($urandom % 7)));
            tick(1);
        end
        finish_run();
    end
endmodule